// File: doc/BRIEF.md
# Speculation Shadow Tracker with Single-Cycle Cancel

This block sits beside the issue logic of a scoreboard-style out-of-order core that has a pool of function units. It tracks the speculation shadows those units are under. Any unit that issues as a branch, predicate or exception-capable operation can claim a shadow row. Every unit that issues while that row is open gets its own bit in the row. A unit whose column holds any set bit may finish its computation, but its result write is held back.

When the owning unit resolves, it pulses one of two inputs. A success pulse drops the row, which frees its dependants to write. A fail pulse drops the row and returns every unit with a bit in that row to idle, all in the same clock edge, however many units are involved. The bits are held per unit rather than chained, so the time a rollback takes does not depend on what was speculated.

The block also handles vector elements whose predicate is not known at issue. Such an element is held until the mask arrives, and is then either released or dropped without writing. Elements whose predicate is already known to be false are never issued. An issue-order matrix tells the exception logic which busy unit is the oldest.

Top module: `shadow_cancel_matrix`

## Requirements
- R1: After reset every unit is idle and no shadow row is open, so `fu_busy`, `wr_en` and `exc_eval` are all zero.
- R2: An issue is accepted (`iss_accept`=1, the unit busy from the next cycle) only when all of these hold: `iss_valid` is high, the target unit is idle, the issue is not a known-false element, no fail pulse hits an open row in that cycle, and a casting issue names a row that is not open.
- R3: An accepted unit receives a bit in every row that is open and not resolving in its issue cycle. A row that resolves in the same cycle leaves no bit on it.
- R4: `wr_en[f]` is high only when unit f is busy, its `res_ready` is high, its column holds no set bit, it has no pending predicate and it owns no open row. A unit with `wr_en` high is idle in the next cycle.
- R5: A success pulse on an open row closes that row only. Units that were blocked solely by that row may write in the next cycle.
- R6: A fail pulse on an open row returns every unit with a bit in that row to idle at the next edge, whatever the count or pattern of those units, and closes the row.
- R7: A fail also closes every row whose owning unit had a bit in the failing row.
- R8: A unit that owns an open row never writes. Its write is allowed again once the row closes.
- R9: An element issue with `iss_pknown`=1 and `iss_pbit`=0 is not accepted and changes no state.
- R10: An element issued with `iss_pknown`=0 never writes until `pm_valid` arrives. At that point, unit f is dropped to idle if `pm[f]`=0 and released to write if `pm[f]`=1.
- R11: `exc_eval[f]` is high when unit f is busy, `wr_haz[f]` is low, and f was issued earlier than every other busy unit. At most one unit is ever the oldest.
- R12: Success or fail pulses on rows that are not open have no effect and do not block issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_fu | input | IW | Target function unit index |
| iss_cast | input | 1 | Issued operation claims a shadow row |
| iss_row | input | RW | Shadow row claimed when `iss_cast` is high |
| iss_elem | input | 1 | Issue is a predicated vector element |
| iss_pknown | input | 1 | Element predicate already known |
| iss_pbit | input | 1 | Known predicate value |
| iss_accept | output | 1 | Issue taken this cycle |
| res_ready | input | N | Per-unit result available |
| wr_haz | input | N | Per-unit outstanding write hazard |
| rs_ok | input | S | Per-row success pulse |
| rs_fail | input | S | Per-row fail pulse |
| pm_valid | input | 1 | Predicate mask delivered |
| pm | input | N | Predicate mask, one bit per unit |
| wr_en | output | N | Per-unit result write permit |
| exc_eval | output | N | Per-unit exception may be evaluated |
| fu_busy | output | N | Per-unit busy |

## Verification
The bench builds the block with four function units and two shadow rows. With that size, every subset of the three non-casting units can be placed under a single caster, and each subset can be resolved both ways. This covers all shadow patterns for the R5 and R6 cancel and release behaviour. All four patterns of a two-element predicate mask are swept as well. The second row makes nested casters reachable, including a fail on an outer row that must also close the inner row. Same-cycle collisions between issue and resolution are reachable too.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int MAX_FU = 64;

  // true when no busy unit is marked as issued ahead of this one
  function automatic logic fu_oldest(input logic [MAX_FU-1:0] ahead_col,
                                     input logic [MAX_FU-1:0] busy_v);
    return ~|(ahead_col & busy_v);
  endfunction

  // write permit for one unit
  function automatic logic fu_may_write(input logic busy, input logic ready,
                                        input logic shadowed, input logic pwait,
                                        input logic holds);
    return busy & ready & ~shadowed & ~pwait & ~holds;
  endfunction
endpackage

// File: rtl/scm_fu_table.sv
module scm_fu_table #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_go,
  input  logic [IW-1:0] iss_fu,
  input  logic          iss_pwait,
  input  logic [N-1:0]  kill,
  input  logic [N-1:0]  retire,
  input  logic          pm_valid,
  input  logic [N-1:0]  pm,
  output logic [N-1:0]  busy,
  output logic [N-1:0]  pwait,
  output logic [N-1:0]  oldest
);
  import scm_pkg::*;

  logic [N-1:0] busy_q, pwait_q;
  logic [N-1:0] ahead_q [N];  // ahead_q[j][i]: unit i issued before unit j

  always_comb begin
    for (int j = 0; j < N; j++)
      oldest[j] = busy_q[j] & fu_oldest(MAX_FU'(ahead_q[j]), MAX_FU'(busy_q));
  end

  assign busy  = busy_q;
  assign pwait = pwait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= '0;
      pwait_q <= '0;
      for (int j = 0; j < N; j++) ahead_q[j] <= '0;
    end else begin
      for (int f = 0; f < N; f++) begin
        if (iss_go && iss_fu == IW'(f)) begin
          busy_q[f]  <= 1'b1;
          pwait_q[f] <= iss_pwait;
          ahead_q[f] <= busy_q;
        end else begin
          if (iss_go) ahead_q[f][iss_fu] <= 1'b0;
          if (kill[f] || retire[f]) begin
            busy_q[f]  <= 1'b0;
            pwait_q[f] <= 1'b0;
          end else if (pm_valid && pwait_q[f]) begin
            pwait_q[f] <= 1'b0;
            if (!pm[f]) busy_q[f] <= 1'b0;
          end
        end
      end
    end
  end

  a_r11_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oldest));

  for (genvar f = 0; f < N; f++) begin : g_chk
    a_r10_mask_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_valid && pwait_q[f] && !pm[f]) |=> !busy_q[f]);
  end
endmodule

// File: rtl/scm_shadow_rows.sv
module scm_shadow_rows #(
  parameter int N = 8,
  parameter int S = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int RW = (S > 1) ? $clog2(S) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_go,
  input  logic [IW-1:0] iss_fu,
  input  logic          iss_cast,
  input  logic [RW-1:0] iss_row,
  input  logic [S-1:0]  rs_ok,
  input  logic [S-1:0]  rs_fail,
  output logic [S-1:0]  row_open,
  output logic [N-1:0]  shadowed,
  output logic [N-1:0]  kill,
  output logic [N-1:0]  holds,
  output logic          any_fail
);
  logic [N-1:0]  sh_q [S];
  logic [S-1:0]  open_q;
  logic [IW-1:0] owner_q [S];
  logic [S-1:0]  direct, rowkill, release_r;

  assign direct   = rs_fail & open_q;
  assign any_fail = |direct;
  assign row_open = open_q;

  always_comb begin
    kill     = '0;
    shadowed = '0;
    holds    = '0;
    for (int r = 0; r < S; r++) begin
      for (int f = 0; f < N; f++) begin
        if (direct[r] && sh_q[r][f]) kill[f] = 1'b1;
        if (sh_q[r][f]) shadowed[f] = 1'b1;
        if (open_q[r] && owner_q[r] == IW'(f)) holds[f] = 1'b1;
      end
    end
    for (int r = 0; r < S; r++) begin
      rowkill[r] = direct[r];
      for (int q = 0; q < S; q++)
        if (direct[q] && sh_q[q][owner_q[r]]) rowkill[r] = 1'b1;
      rowkill[r] = rowkill[r] & open_q[r];
    end
    release_r = rowkill | (rs_ok & open_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int r = 0; r < S; r++) begin
        sh_q[r]    <= '0;
        owner_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < S; r++) begin
        if (release_r[r]) begin
          open_q[r] <= 1'b0;
          sh_q[r]   <= '0;
        end else begin
          if (iss_go) sh_q[r][iss_fu] <= open_q[r];
          if (iss_go && iss_cast && iss_row == RW'(r)) begin
            open_q[r]  <= 1'b1;
            sh_q[r]    <= '0;
            owner_q[r] <= iss_fu;
          end
        end
      end
    end
  end

  for (genvar r = 0; r < S; r++) begin : g_chk
    a_r5_ok_closes_row: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_ok[r] && open_q[r]) |=> !open_q[r]);
    a_r12_idle_pulse_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((rs_ok[r] || rs_fail[r]) && !open_q[r] &&
       !(iss_go && iss_cast && iss_row == RW'(r))) |=> !open_q[r]);
  end
endmodule

// File: rtl/shadow_cancel_matrix.sv
module shadow_cancel_matrix #(
  parameter int N = 8,
  parameter int S = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int RW = (S > 1) ? $clog2(S) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [IW-1:0] iss_fu,
  input  logic          iss_cast,
  input  logic [RW-1:0] iss_row,
  input  logic          iss_elem,
  input  logic          iss_pknown,
  input  logic          iss_pbit,
  output logic          iss_accept,
  input  logic [N-1:0]  res_ready,
  input  logic [N-1:0]  wr_haz,
  input  logic [S-1:0]  rs_ok,
  input  logic [S-1:0]  rs_fail,
  input  logic          pm_valid,
  input  logic [N-1:0]  pm,
  output logic [N-1:0]  wr_en,
  output logic [N-1:0]  exc_eval,
  output logic [N-1:0]  fu_busy
);
  import scm_pkg::*;

  logic [N-1:0] busy, pwait, oldest, shadowed, kill, holds;
  logic [S-1:0] row_open;
  logic         any_fail, known_false, row_taken, fu_in_range, iss_pwait;

  assign fu_in_range = int'(iss_fu) < N;
  assign known_false = iss_elem & iss_pknown & ~iss_pbit;
  assign row_taken   = iss_cast & (int'(iss_row) < S) & row_open[iss_row];
  assign iss_accept  = iss_valid & fu_in_range & ~busy[iss_fu] & ~known_false &
                       ~any_fail & ~row_taken & ~(iss_cast & ~(int'(iss_row) < S));
  assign iss_pwait   = iss_elem & ~iss_pknown;

  always_comb begin
    for (int f = 0; f < N; f++)
      wr_en[f] = fu_may_write(busy[f], res_ready[f], shadowed[f], pwait[f], holds[f]);
  end

  assign exc_eval = busy & ~wr_haz & oldest;
  assign fu_busy  = busy;

  scm_shadow_rows #(.N(N), .S(S)) u_rows (
    .clk(clk), .rst_n(rst_n), .iss_go(iss_accept), .iss_fu(iss_fu),
    .iss_cast(iss_cast), .iss_row(iss_row), .rs_ok(rs_ok), .rs_fail(rs_fail),
    .row_open(row_open), .shadowed(shadowed), .kill(kill), .holds(holds),
    .any_fail(any_fail)
  );

  scm_fu_table #(.N(N)) u_fus (
    .clk(clk), .rst_n(rst_n), .iss_go(iss_accept), .iss_fu(iss_fu),
    .iss_pwait(iss_pwait), .kill(kill), .retire(wr_en), .pm_valid(pm_valid),
    .pm(pm), .busy(busy), .pwait(pwait), .oldest(oldest)
  );

  a_r6_fail_kills_all: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill) |=> ((busy & $past(kill & busy)) == '0));

  for (genvar f = 0; f < N; f++) begin : g_chk
    a_r4_write_retires: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[f] |=> !busy[f]);
  end
endmodule

// File: tb/tb_shadow_cancel_matrix.sv
`timescale 1ns/1ps
module tb_shadow_cancel_matrix;
  localparam int N = 4;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0, iss_cast = 1'b0, iss_elem = 1'b0;
  logic iss_pknown = 1'b0, iss_pbit = 1'b0, pm_valid = 1'b0;
  logic [1:0] iss_fu = '0;
  logic [0:0] iss_row = '0;
  logic [N-1:0] res_ready = '0, wr_haz = '0, pm = '0;
  logic [S-1:0] rs_ok = '0, rs_fail = '0;
  logic iss_accept;
  logic [N-1:0] wr_en, exc_eval, fu_busy;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  shadow_cancel_matrix #(.N(N), .S(S)) dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_fu(iss_fu),
    .iss_cast(iss_cast), .iss_row(iss_row), .iss_elem(iss_elem),
    .iss_pknown(iss_pknown), .iss_pbit(iss_pbit), .iss_accept(iss_accept),
    .res_ready(res_ready), .wr_haz(wr_haz), .rs_ok(rs_ok), .rs_fail(rs_fail),
    .pm_valid(pm_valid), .pm(pm), .wr_en(wr_en), .exc_eval(exc_eval),
    .fu_busy(fu_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    iss_valid = 0; rs_ok = '0; rs_fail = '0; pm_valid = 0; res_ready = '0; wr_haz = '0;
    rst_n = 0; tick; tick; rst_n = 1; #1;
  endtask

  task automatic issue(input int fu, input logic cast, input int row,
                       input logic elem, input logic pk, input logic pb);
    iss_valid = 1; iss_fu = 2'(fu); iss_cast = cast; iss_row = 1'(row);
    iss_elem = elem; iss_pknown = pk; iss_pbit = pb;
    tick;
    iss_valid = 0; iss_cast = 0; iss_elem = 0; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset;
    res_ready = '1;
    #1;
    chk("R1 busy after reset", 32'(fu_busy), 0);
    chk("R1 wr_en after reset", 32'(wr_en), 0);
    chk("R1 exc_eval after reset", 32'(exc_eval), 0);

    // R5 R6 R8: every subset of units 0..2 under caster unit 3 on row 0
    for (int m = 0; m < 8; m++) begin
      for (int oc = 0; oc < 2; oc++) begin
        do_reset;
        res_ready = '1;
        issue(3, 1, 0, 0, 0, 0);
        for (int u = 0; u < 3; u++) if (m[u]) issue(u, 0, 0, 0, 0, 0);
        chk("R2 busy after issues", 32'(fu_busy), 32'(m | 8));
        chk("R4 R8 writes blocked under shadow", 32'(wr_en), 0);
        if (oc == 1) rs_fail[0] = 1; else rs_ok[0] = 1;
        #1;
        chk("R4 blocked during resolve cycle", 32'(wr_en), 0);
        tick;
        rs_fail = '0; rs_ok = '0; #1;
        if (oc == 1) begin
          chk("R6 fail cancels all shadowed", 32'(fu_busy), 8);
          chk("R8 caster writes after fail", 32'(wr_en), 8);
        end else begin
          chk("R5 success frees shadowed", 32'(wr_en), 32'(m | 8));
        end
        tick;
        chk("R4 writers retire", 32'(fu_busy), 0);
      end
    end

    // R7 nested casters
    do_reset;
    issue(0, 1, 0, 0, 0, 0);
    issue(1, 1, 1, 0, 0, 0);
    issue(2, 0, 0, 0, 0, 0);
    chk("R2 nested busy", 32'(fu_busy), 7);
    rs_fail[0] = 1; tick; rs_fail = '0; #1;
    chk("R7 outer fail clears inner", 32'(fu_busy), 1);
    iss_valid = 1; iss_fu = 1; iss_cast = 1; iss_row = 1; #1;
    chk("R7 inner row closed by outer fail", 32'(iss_accept), 1);
    iss_valid = 0; iss_cast = 0;
    res_ready = 4'b0001; #1;
    chk("R8 outer caster may write", 32'(wr_en), 1);
    res_ready = '0;

    // R2 issue in the same cycle as a fail
    do_reset;
    issue(3, 1, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0);
    rs_fail[0] = 1; iss_valid = 1; iss_fu = 1; #1;
    chk("R2 issue rejected on fail", 32'(iss_accept), 0);
    tick; rs_fail = '0; iss_valid = 0; #1;
    chk("R2 R6 state after fail", 32'(fu_busy), 8);
    iss_valid = 1; iss_fu = 3; #1;
    chk("R2 busy target rejected", 32'(iss_accept), 0);
    iss_valid = 0;

    // R3 issue in the same cycle as a success
    do_reset;
    issue(3, 1, 0, 0, 0, 0);
    rs_ok[0] = 1;
    issue(0, 0, 0, 0, 0, 0);
    rs_ok = '0; res_ready = '1; #1;
    chk("R3 no bit from resolving row", 32'(wr_en), 9);
    res_ready = '0;
    // R3 unit issued into open row is marked
    do_reset;
    issue(3, 1, 1, 0, 0, 0);
    issue(2, 0, 0, 0, 0, 0);
    res_ready = 4'b0100; #1;
    chk("R3 marked by open row", 32'(wr_en), 0);
    res_ready = '0;

    // R12 pulses on closed rows
    do_reset;
    issue(0, 0, 0, 0, 0, 0);
    issue(1, 0, 0, 0, 0, 0);
    rs_fail = 2'b11; rs_ok = 2'b11; iss_valid = 1; iss_fu = 2; #1;
    chk("R12 idle pulses do not block issue", 32'(iss_accept), 1);
    tick; rs_fail = '0; rs_ok = '0; iss_valid = 0; #1;
    chk("R12 idle pulses keep units", 32'(fu_busy), 7);

    // R11 oldest-unit exception evaluation
    do_reset;
    issue(0, 0, 0, 0, 0, 0);
    issue(1, 0, 0, 0, 0, 0);
    issue(2, 0, 0, 0, 0, 0);
    chk("R11 oldest is unit 0", 32'(exc_eval), 1);
    wr_haz = 4'b0001; #1;
    chk("R11 hazard holds evaluation", 32'(exc_eval), 0);
    wr_haz = '0; res_ready = 4'b0001; tick; res_ready = '0; #1;
    chk("R11 next oldest is unit 1", 32'(exc_eval), 2);
    issue(0, 0, 0, 0, 0, 0);
    chk("R11 reissued unit is youngest", 32'(exc_eval), 2);

    // R10 every mask pattern for two pending elements
    for (int p = 0; p < 4; p++) begin
      do_reset;
      issue(0, 0, 0, 1, 0, 0);
      issue(1, 0, 0, 1, 0, 0);
      res_ready = '1; #1;
      chk("R10 pending elements blocked", 32'(wr_en), 0);
      pm_valid = 1; pm = 4'(p); tick; pm_valid = 0; pm = '0; #1;
      chk("R10 masked elements dropped", 32'(fu_busy), 32'(p));
      chk("R10 only unmasked elements write", 32'(wr_en), 32'(p));
      res_ready = '0;
    end

    // R9 known-false element is not issued
    do_reset;
    issue(0, 0, 0, 0, 0, 0);
    iss_valid = 1; iss_fu = 2; iss_elem = 1; iss_pknown = 1; iss_pbit = 0; #1;
    chk("R9 known-false not accepted", 32'(iss_accept), 0);
    tick; iss_valid = 0; iss_elem = 0; #1;
    chk("R9 state unchanged", 32'(fu_busy), 1);
    issue(2, 0, 0, 1, 1, 1);
    res_ready = 4'b0100; #1;
    chk("R9 known-true element writes", 32'(wr_en), 4);
    res_ready = '0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule